// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit core and a byte-addressed, 32-bit-wide data memory port. For a load it takes the aligned word read from memory, the two low address bits, the access kind and the current contents of the destination register. From these it produces the value to write back. For a store it takes the register value and produces the memory write data and four byte-lane enables.

It handles byte, halfword and word accesses, with sign- or zero-extension on narrow loads. It also handles left and right partial-word accesses. A pair of these lets software load or store one unaligned word in two instructions: a left access and a right access, each covering the bytes that fall in one aligned word. For partial loads, the register bytes that are not taken from memory keep their old value.

Byte order is picked once, from a strap input that is sampled while reset is held. It stays fixed until the next reset. Big-endian is the usual strapping. The unit is combinational apart from that one endianness flop.

Top module: `lsu_lane_align`

## Requirements
- R1: While `rst_n` is low, `strap_big` is captured at each rising clock edge into the byte-order flag (1 = big-endian, 0 = little-endian). Once `rst_n` is high the flag holds, whatever `strap_big` does, and `big_mode` shows it.
- R2: Memory lane i is `mem_rdata[8i+7:8i]`, and a store enable bit `store_be[i]` covers the same lane. With little-endian order, address offset `addr_lo` selects lane `addr_lo`. With big-endian order it selects lane 3-`addr_lo`. The access kind codes are 0 byte, 1 halfword, 2 word, 3 left, 4 right.
- R3: A byte load returns the selected lane. Bits 31:8 are copies of bit 7 when `acc_unsigned`=0, and are zero when `acc_unsigned`=1. So lane value 0xFE gives 0xFFFF_FFFE or 0x0000_00FE.
- R4: A halfword load returns the two lanes that hold offsets `addr_lo` and `addr_lo`+1 as a 16-bit value, then sign- or zero-extends it as in R3. This is lanes 3:2 for big-endian offset 0 or little-endian offset 2, and lanes 1:0 otherwise.
- R5: A word load at offset 0 returns `mem_rdata` unchanged.
- R6: A left load with selected lane k shifts the memory word left by 8*(3-k) bits into the result. The 8*(3-k) low bits of the result are taken from `reg_old`.
- R7: A right load with selected lane k shifts the memory word right by 8*k bits into the result. The 8*k high bits of the result are taken from `reg_old`.
- R8: A byte store writes `reg_wdata[7:0]` into all four lanes and enables only the selected lane. A halfword store writes `reg_wdata[15:0]` into both halves and enables only the half chosen as in R4.
- R9: A word store at offset 0 writes `reg_wdata` and enables all four lanes.
- R10: A left store with selected lane k writes `reg_wdata` shifted right by 8*(3-k) bits and enables lanes 0..k. A right store writes `reg_wdata` shifted left by 8*k bits and enables lanes k..3.
- R11: `align_err` rises for a halfword access with `addr_lo[0]`=1, for a word access with `addr_lo`!=0, and for any kind code above 4. While it is high, `store_be` is 0 and `load_result` equals `reg_old`.
- R12: `store_be` is 0 for every load and whenever `acc_en` is 0. `align_err` is 0 whenever `acc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_big | input | 1 | Byte-order strap, sampled during reset (1 = big-endian) |
| acc_en | input | 1 | Access present this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_kind | input | 3 | Access kind code (see R2) |
| acc_unsigned | input | 1 | Zero-extend narrow loads |
| addr_lo | input | 2 | Low two bits of the byte address |
| mem_rdata | input | 32 | Aligned word read from memory |
| reg_old | input | 32 | Current destination register contents |
| reg_wdata | input | 32 | Register value to store |
| load_result | output | 32 | Value to write back to the register |
| store_data | output | 32 | Memory write data, lane-aligned |
| store_be | output | 4 | Per-lane write enables |
| align_err | output | 1 | Misaligned or unknown access |
| big_mode | output | 1 | Latched byte order (1 = big-endian) |

## Verification
The bench runs every access kind at a non-zero offset in both byte orders, using one memory word whose lanes hold distinct values with mixed sign bits. A design that reversed the lane index for one order, or that sign-extended from the wrong bit, would therefore return a visibly wrong value. The partial-word cases check the exact split between new and old bytes, so an off-by-one lane count in a left or right merge would show up as one byte from the wrong source. Misaligned halfword and word accesses and an unknown kind code must suppress all enables and pass the old register through; a design that only flagged the error would still write memory. The strap is toggled after reset to catch a byte order that keeps tracking the pin.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_big,
  input  logic        acc_en,
  input  logic        acc_store,
  input  logic [2:0]  acc_kind,
  input  logic        acc_unsigned,
  input  logic [1:0]  addr_lo,
  input  logic [31:0] mem_rdata,
  input  logic [31:0] reg_old,
  input  logic [31:0] reg_wdata,
  output logic [31:0] load_result,
  output logic [31:0] store_data,
  output logic [3:0]  store_be,
  output logic        align_err,
  output logic        big_mode
);

  localparam logic [2:0] KIND_BYTE  = 3'd0;
  localparam logic [2:0] KIND_HALF  = 3'd1;
  localparam logic [2:0] KIND_WORD  = 3'd2;
  localparam logic [2:0] KIND_LEFT  = 3'd3;
  localparam logic [2:0] KIND_RIGHT = 3'd4;

  logic big_q;

  always_ff @(posedge clk) begin
    if (!rst_n) big_q <= strap_big;
  end

  assign big_mode = big_q;

  logic [1:0]  lane;
  logic        upper_half;
  logic [4:0]  lsh, rsh;
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;
  logic [31:0] keep_left, keep_right;
  logic        bad;

  assign lane       = big_q ? ~addr_lo : addr_lo;
  assign upper_half = big_q ? ~addr_lo[1] : addr_lo[1];
  assign lsh        = {~lane, 3'b000};
  assign rsh        = {lane, 3'b000};
  assign sel_byte   = 8'(mem_rdata >> rsh);
  assign sel_half   = upper_half ? mem_rdata[31:16] : mem_rdata[15:0];
  assign keep_left  = ~(32'hFFFF_FFFF << lsh);
  assign keep_right = ~(32'hFFFF_FFFF >> rsh);

  assign bad = acc_en && ((acc_kind == KIND_HALF && addr_lo[0]) ||
                          (acc_kind == KIND_WORD && addr_lo != 2'b00) ||
                          (acc_kind > KIND_RIGHT));

  always_comb begin
    load_result = reg_old;
    if (!bad) begin
      case (acc_kind)
        KIND_BYTE:  load_result = {{24{sel_byte[7] & ~acc_unsigned}}, sel_byte};
        KIND_HALF:  load_result = {{16{sel_half[15] & ~acc_unsigned}}, sel_half};
        KIND_WORD:  load_result = mem_rdata;
        KIND_LEFT:  load_result = (mem_rdata << lsh) | (reg_old & keep_left);
        KIND_RIGHT: load_result = (mem_rdata >> rsh) | (reg_old & keep_right);
        default:    load_result = reg_old;
      endcase
    end
  end

  logic [3:0] be_raw;

  always_comb begin
    store_data = reg_wdata;
    be_raw     = 4'b0000;
    case (acc_kind)
      KIND_BYTE: begin
        store_data = {4{reg_wdata[7:0]}};
        be_raw     = 4'b0001 << lane;
      end
      KIND_HALF: begin
        store_data = {2{reg_wdata[15:0]}};
        be_raw     = upper_half ? 4'b1100 : 4'b0011;
      end
      KIND_WORD: be_raw = 4'b1111;
      KIND_LEFT: begin
        store_data = reg_wdata >> lsh;
        be_raw     = 4'b1111 >> ~lane;
      end
      KIND_RIGHT: begin
        store_data = reg_wdata << rsh;
        be_raw     = 4'b1111 << lane;
      end
      default: be_raw = 4'b0000;
    endcase
  end

  assign store_be  = (acc_en && acc_store && !bad) ? be_raw : 4'b0000;
  assign align_err = bad;

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_en,
  input logic        acc_store,
  input logic [2:0]  acc_kind,
  input logic        acc_unsigned,
  input logic [1:0]  addr_lo,
  input logic [31:0] reg_old,
  input logic [31:0] load_result,
  input logic [3:0]  store_be,
  input logic        align_err,
  input logic        big_mode
);

  logic [1:0] lane_c;
  assign lane_c = big_mode ? ~addr_lo : addr_lo;

  assert_order_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(big_mode));

  assert_ubyte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_store && acc_kind == 3'd0 && acc_unsigned) |-> load_result[31:8] == 24'd0);

  assert_left_keeps_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_store && acc_kind == 3'd3 && lane_c != 2'd3) |-> load_result[7:0] == reg_old[7:0]);

  assert_right_keeps_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_store && acc_kind == 3'd4 && lane_c != 2'd0) |-> load_result[31:24] == reg_old[31:24]);

  assert_byte_one_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_store && acc_kind == 3'd0) |-> $countones(store_be) == 1);

  assert_word_all_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_store && acc_kind == 3'd2 && !align_err) |-> store_be == 4'b1111);

  assert_err_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (store_be == 4'b0000 && load_result == reg_old));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en || !acc_store) |-> (store_be == 4'b0000 && (acc_en || !align_err)));

endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_store(acc_store),
  .acc_kind(acc_kind), .acc_unsigned(acc_unsigned), .addr_lo(addr_lo),
  .reg_old(reg_old), .load_result(load_result), .store_be(store_be),
  .align_err(align_err), .big_mode(big_mode)
);

// File: tb/lsu_lane_align_tb.sv
`timescale 1ns/1ps
module lsu_lane_align_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_big = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_store = 1'b0;
  logic [2:0]  acc_kind = 3'd0;
  logic        acc_unsigned = 1'b0;
  logic [1:0]  addr_lo = 2'd0;
  logic [31:0] mem_rdata = 32'hFE81_7C05;
  logic [31:0] reg_old = 32'hDEAD_BEEF;
  logic [31:0] reg_wdata = 32'h1234_5678;
  logic [31:0] load_result, store_data;
  logic [3:0]  store_be;
  logic        align_err, big_mode;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lsu_lane_align u_dut (
    .clk(clk), .rst_n(rst_n), .strap_big(strap_big), .acc_en(acc_en),
    .acc_store(acc_store), .acc_kind(acc_kind), .acc_unsigned(acc_unsigned),
    .addr_lo(addr_lo), .mem_rdata(mem_rdata), .reg_old(reg_old),
    .reg_wdata(reg_wdata), .load_result(load_result), .store_data(store_data),
    .store_be(store_be), .align_err(align_err), .big_mode(big_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [2:0] k, input logic u, input logic [1:0] a);
    @(negedge clk);
    acc_en = 1'b1; acc_store = st; acc_kind = k; acc_unsigned = u; addr_lo = a;
    #2;
  endtask

  task automatic do_reset(input logic big);
    @(negedge clk);
    rst_n = 1'b0; strap_big = big; acc_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
  endtask

  task automatic t_reset_order();
    do_reset(1'b1);
    chk("R1 big strap", {31'd0, big_mode}, 32'd1);
    strap_big = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 strap ignored after reset", {31'd0, big_mode}, 32'd1);
    drive(1'b0, 3'd0, 1'b1, 2'd0);
    chk("R1 R2 still big lane3", load_result, 32'h0000_00FE);
  endtask

  task automatic t_big_loads();
    drive(1'b0, 3'd0, 1'b0, 2'd0); chk("R3 big lb a0", load_result, 32'hFFFF_FFFE);
    drive(1'b0, 3'd0, 1'b1, 2'd0); chk("R3 big lbu a0", load_result, 32'h0000_00FE);
    drive(1'b0, 3'd0, 1'b0, 2'd1); chk("R3 R2 big lb a1", load_result, 32'hFFFF_FF81);
    drive(1'b0, 3'd0, 1'b0, 2'd3); chk("R3 R2 big lb a3", load_result, 32'h0000_0005);
    drive(1'b0, 3'd1, 1'b0, 2'd0); chk("R4 big lh a0", load_result, 32'hFFFF_FE81);
    drive(1'b0, 3'd1, 1'b1, 2'd2); chk("R4 big lhu a2", load_result, 32'h0000_7C05);
    drive(1'b0, 3'd2, 1'b0, 2'd0); chk("R5 big lw", load_result, 32'hFE81_7C05);
    chk("R12 load no enables", {28'd0, store_be}, 32'd0);
    drive(1'b0, 3'd3, 1'b0, 2'd1); chk("R6 big left a1", load_result, 32'h817C_05EF);
    drive(1'b0, 3'd3, 1'b0, 2'd0); chk("R6 big left a0", load_result, 32'hFE81_7C05);
    drive(1'b0, 3'd4, 1'b0, 2'd1); chk("R7 big right a1", load_result, 32'hDEAD_FE81);
    drive(1'b0, 3'd4, 1'b0, 2'd3); chk("R7 big right a3", load_result, 32'hFE81_7C05);
  endtask

  task automatic t_big_stores();
    drive(1'b1, 3'd0, 1'b0, 2'd1);
    chk("R8 big sb data", store_data, 32'h7878_7878);
    chk("R8 big sb be", {28'd0, store_be}, 32'h4);
    drive(1'b1, 3'd1, 1'b0, 2'd2);
    chk("R8 big sh data", store_data, 32'h5678_5678);
    chk("R8 big sh be", {28'd0, store_be}, 32'h3);
    drive(1'b1, 3'd2, 1'b0, 2'd0);
    chk("R9 big sw data", store_data, 32'h1234_5678);
    chk("R9 big sw be", {28'd0, store_be}, 32'hF);
    drive(1'b1, 3'd3, 1'b0, 2'd1);
    chk("R10 big swl data", store_data, 32'h0012_3456);
    chk("R10 big swl be", {28'd0, store_be}, 32'h7);
    drive(1'b1, 3'd4, 1'b0, 2'd1);
    chk("R10 big swr data", store_data, 32'h5678_0000);
    chk("R10 big swr be", {28'd0, store_be}, 32'hC);
  endtask

  task automatic t_little();
    do_reset(1'b0);
    chk("R1 little strap", {31'd0, big_mode}, 32'd0);
    drive(1'b0, 3'd0, 1'b0, 2'd0); chk("R3 R2 little lb a0", load_result, 32'h0000_0005);
    drive(1'b0, 3'd0, 1'b0, 2'd3); chk("R3 R2 little lb a3", load_result, 32'hFFFF_FFFE);
    drive(1'b0, 3'd1, 1'b0, 2'd2); chk("R4 little lh a2", load_result, 32'hFFFF_FE81);
    drive(1'b0, 3'd1, 1'b1, 2'd0); chk("R4 little lhu a0", load_result, 32'h0000_7C05);
    drive(1'b0, 3'd3, 1'b0, 2'd1); chk("R6 little left a1", load_result, 32'h7C05_BEEF);
    drive(1'b0, 3'd4, 1'b0, 2'd1); chk("R7 little right a1", load_result, 32'hDEFE_817C);
    drive(1'b1, 3'd0, 1'b0, 2'd1); chk("R8 little sb be", {28'd0, store_be}, 32'h2);
    drive(1'b1, 3'd1, 1'b0, 2'd2); chk("R8 little sh be", {28'd0, store_be}, 32'hC);
    drive(1'b1, 3'd3, 1'b0, 2'd2);
    chk("R10 little swl data", store_data, 32'h0012_3456);
    chk("R10 little swl be", {28'd0, store_be}, 32'h7);
    drive(1'b1, 3'd4, 1'b0, 2'd1);
    chk("R10 little swr data", store_data, 32'h3456_7800);
    chk("R10 little swr be", {28'd0, store_be}, 32'hE);
  endtask

  task automatic t_errors();
    drive(1'b1, 3'd2, 1'b0, 2'd2);
    chk("R11 sw misaligned err", {31'd0, align_err}, 32'd1);
    chk("R11 sw misaligned be", {28'd0, store_be}, 32'd0);
    drive(1'b0, 3'd1, 1'b0, 2'd1);
    chk("R11 lh misaligned err", {31'd0, align_err}, 32'd1);
    chk("R11 lh misaligned result", load_result, 32'hDEAD_BEEF);
    drive(1'b1, 3'd5, 1'b0, 2'd0);
    chk("R11 unknown kind err", {31'd0, align_err}, 32'd1);
    chk("R11 unknown kind be", {28'd0, store_be}, 32'd0);
    drive(1'b1, 3'd3, 1'b0, 2'd1);
    chk("R11 left never misaligned", {31'd0, align_err}, 32'd0);
  endtask

  task automatic t_idle();
    drive(1'b1, 3'd2, 1'b0, 2'd1);
    acc_en = 1'b0;
    #2;
    chk("R12 idle no err", {31'd0, align_err}, 32'd0);
    chk("R12 idle no enables", {28'd0, store_be}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_order();
    t_big_loads();
    t_big_stores();
    t_errors();
    t_idle();
    t_little();
    t_errors();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule